// File: doc/BRIEF.md
# Event Log Record Packer

This block collects timestamped packet event records from several producers: one ingress stage and a number of transmit stages. An event is either an arrival or a departure. A departure record carries the same identifier and buffer pointer as the arrival record it pairs with. Each record is 61 bits wide and holds these fields:

- packet ID
- timestamp, counted in 8 ns clock cycles
- buffer pointer
- remaining hop count
- lag
- port number

Each producer hands records over through a one-entry holding register that applies backpressure. A round-robin arbiter moves one held record per cycle into a shared record FIFO. When the FIFO holds a full batch of records, a framer streams a report frame towards the host port. The frame is one fixed header word followed by one zero-padded 64-bit word per record. The host can then rebuild a hardware-timed trace of packet events.

The output stream may stall. If the FIFO is full when a record is granted, that record is discarded and a saturating overflow counter is incremented. The producers are never stalled indefinitely.

Top module: `evlog_packer`

## Requirements
- R1: A record word carries zeros in bits 63..61 and the 61-bit record in bits 60..0. The record fields run from the top bit downwards: packet ID (12 bits), time (19), buffer pointer (19), hop count (4), lag (5), port number (2).
- R2: Each frame consists of the header word `HDR_WORD` followed by exactly `RECS_PER_FRAME` record words. `out_last` is high only on the final record word.
- R3: `out_valid` rises only when the FIFO holds at least `RECS_PER_FRAME` records. It stays low between frames otherwise.
- R4: Record words leave in the order in which records entered the FIFO. No record is repeated or lost, except records dropped under R7.
- R5: In each cycle the arbiter grants one occupied holding register. It searches from the current priority index upwards, wrapping around. The priority index then moves to the index just after the winner.
- R6: `src_ready[i]` is low while holding register i is occupied. A record offered while it is low is ignored and does not alter the stored record.
- R7: A record granted while the FIFO already holds `FIFO_DEPTH` entries is discarded, and `ovf_count` increases by one.
- R8: `ovf_count` saturates at its maximum value and stays there until reset.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R10: After reset, every `src_ready` bit is high, `out_valid` is low and `ovf_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_valid | input | N_SRC | Per-producer record offer |
| src_rec | input | N_SRC*61 | Per-producer record; producer i uses bits [61*i+60 : 61*i] |
| src_ready | output | N_SRC | Per-producer holding register is free |
| out_valid | output | 1 | Frame word available |
| out_data | output | 64 | Frame word (header or padded record) |
| out_last | output | 1 | Final word of the frame |
| out_ready | input | 1 | Host side accepts the word |
| ovf_count | output | OVF_W | Saturating count of discarded records |

## Verification
The assertions assume the following about the inputs:

- A producer keeps its record stable only while the record is offered. Records offered while `src_ready` is low are simply ignored.
- `out_ready` may change in any cycle.

The internal guards assume that only the top level drives FIFO pushes and framer pops. The bench drives its inputs only on the falling clock edge. It renews each producer's record only after the reference model has seen the record accepted. It mixes the following patterns:

- a single producer
- all producers at once
- random producer subsets
- a random ready line
- a long full stall, which fills the FIFO and drives the overflow counter into saturation

// File: rtl/evlog_pkg.sv
`timescale 1ns/1ps
// evlog_pkg: shared field widths, the event record layout and the framer
// state encoding for the event log record packer.
package evlog_pkg;
    localparam int ID_W   = 12;
    localparam int TIME_W = 19;
    localparam int PTR_W  = 19;
    localparam int HOP_W  = 4;
    localparam int LAG_W  = 5;
    localparam int PORT_W = 2;
    localparam int REC_W  = ID_W + TIME_W + PTR_W + HOP_W + LAG_W + PORT_W;
    localparam int WORD_W = 64;

    // Record layout, most significant field first.
    typedef struct packed {
        logic [ID_W-1:0]   pkt_id;
        logic [TIME_W-1:0] stamp;
        logic [PTR_W-1:0]  buf_ptr;
        logic [HOP_W-1:0]  hops;
        logic [LAG_W-1:0]  lag;
        logic [PORT_W-1:0] port;
    } evrec_t;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_HEAD = 2'd1,
        FR_BODY = 2'd2
    } frm_state_t;
endpackage

// File: rtl/evlog_rr_arb.sv
`timescale 1ns/1ps
// evlog_rr_arb: round-robin arbiter. Grants at most one requester per cycle,
// searching upward from a rotating priority index that moves just past the
// winner. Assumes N >= 2 and that a grant is always consumed in its cycle.
module evlog_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] grant_idx,
    output logic                 grant_any
);
    localparam int IDX_W = $clog2(N);

    logic [IDX_W-1:0] prio_q;

    // Search for the first requester at or after the priority index.
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        grant_any = 1'b0;
        for (int k = 0; k < N; k++) begin
            int c;
            c = int'(prio_q) + k;
            if (c >= N) c = c - N;
            if (!grant_any && req[c]) begin
                grant_any = 1'b1;
                grant[c]  = 1'b1;
                grant_idx = IDX_W'(c);
            end
        end
    end

    // Move the priority index just past the winner.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prio_q <= '0;
        else if (grant_any)
            prio_q <= (int'(grant_idx) == N - 1) ? '0 : grant_idx + 1'b1;
    end

    a_r5_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r5_grant_in_req: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);
    a_r5_no_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> grant_any);
endmodule

// File: rtl/evlog_fifo.sv
`timescale 1ns/1ps
// evlog_fifo: record FIFO with a registered occupancy count and a head
// output read straight from storage. Assumes the caller never pushes when
// full and never pops when empty.
module evlog_fifo #(
    parameter int W     = 61,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               din,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    assign head  = mem[rd_q];
    assign count = cnt_q;
    assign full  = (cnt_q == CW'(DEPTH));

    // Write the pushed record into storage.
    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= din;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (int'(wr_q) == DEPTH - 1) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (int'(rd_q) == DEPTH - 1) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r4_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));
endmodule

// File: rtl/evlog_framer.sv
`timescale 1ns/1ps
// evlog_framer: waits until a full batch of records is queued, then emits
// the header word and that batch as zero-padded words on a valid/ready
// stream. Assumes the FIFO count does not fall while it waits (it is the
// only consumer).
module evlog_framer #(
    parameter int          RECS     = 10,
    parameter int          CNT_W    = 5,
    parameter logic [63:0] HDR_WORD = 64'hC0DE_0A0A_5A5A_F00D
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CNT_W-1:0]          fifo_count,
    input  logic [evlog_pkg::REC_W-1:0] fifo_head,
    output logic                      pop,
    output logic                      out_valid,
    output logic [63:0]               out_data,
    output logic                      out_last,
    input  logic                      out_ready
);
    import evlog_pkg::*;
    localparam int IW  = $clog2(RECS);
    localparam int PAD = WORD_W - REC_W;

    frm_state_t    st_q;
    logic [IW-1:0] idx_q;

    // Drive the stream from the state and the FIFO head.
    always_comb begin
        out_valid = (st_q != FR_IDLE);
        out_last  = (st_q == FR_BODY) && (int'(idx_q) == RECS - 1);
        out_data  = (st_q == FR_HEAD) ? HDR_WORD : {{PAD{1'b0}}, fifo_head};
        pop       = (st_q == FR_BODY) && out_ready;
    end

    // Step through the idle, header and body phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= FR_IDLE;
            idx_q <= '0;
        end else begin
            case (st_q)
                FR_IDLE: if (fifo_count >= CNT_W'(RECS)) st_q <= FR_HEAD;
                FR_HEAD: if (out_ready) begin
                    st_q  <= FR_BODY;
                    idx_q <= '0;
                end
                FR_BODY: if (out_ready) begin
                    if (int'(idx_q) == RECS - 1) st_q <= FR_IDLE;
                    else idx_q <= idx_q + 1'b1;
                end
                default: st_q <= FR_IDLE;
            endcase
        end
    end

    a_r9_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
    a_r2_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);
    a_r3_start_needs_batch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (fifo_count >= CNT_W'(RECS)));
endmodule

// File: rtl/evlog_packer.sv
`timescale 1ns/1ps
// evlog_packer: top of the event log record packer. Each producer has a
// one-entry holding register, a round-robin arbiter moves one held record
// per cycle into the record FIFO (or discards it when the FIFO is full,
// counting the loss), and the framer streams batches to the host port.
// Assumes FIFO_DEPTH >= RECS_PER_FRAME and N_SRC >= 2.
module evlog_packer #(
    parameter int          N_SRC          = 4,
    parameter int          FIFO_DEPTH     = 16,
    parameter int          RECS_PER_FRAME = 10,
    parameter int          OVF_W          = 8,
    parameter logic [63:0] HDR_WORD       = 64'hC0DE_0A0A_5A5A_F00D
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [N_SRC-1:0]                  src_valid,
    input  logic [N_SRC*evlog_pkg::REC_W-1:0] src_rec,
    output logic [N_SRC-1:0]                  src_ready,
    output logic                              out_valid,
    output logic [63:0]                       out_data,
    output logic                              out_last,
    input  logic                              out_ready,
    output logic [OVF_W-1:0]                  ovf_count
);
    import evlog_pkg::*;
    localparam int          IDX_W   = $clog2(N_SRC);
    localparam int          CNT_W   = $clog2(FIFO_DEPTH + 1);
    localparam logic [OVF_W-1:0] OVF_MAX = '1;

    logic [N_SRC-1:0] hold_v;
    evrec_t           hold_d [N_SRC];
    logic [N_SRC-1:0] grant;
    logic [IDX_W-1:0] grant_idx;
    logic             grant_any;
    logic             fifo_push, fifo_pop, fifo_full;
    logic [CNT_W-1:0] fifo_count;
    logic [REC_W-1:0] fifo_head;
    logic [OVF_W-1:0] ovf_q;

    assign src_ready = ~hold_v;
    assign ovf_count = ovf_q;

    // One holding register per producer.
    for (genvar g = 0; g < N_SRC; g++) begin : g_hold
        // Capture an offered record when free; release it when granted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_v[g] <= 1'b0;
            end else if (!hold_v[g]) begin
                hold_v[g] <= src_valid[g];
                if (src_valid[g]) hold_d[g] <= src_rec[g*REC_W +: REC_W];
            end else if (grant[g]) begin
                hold_v[g] <= 1'b0;
            end
        end

        a_r6_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_v[g] && !grant[g]) |=> (hold_v[g] && $stable(hold_d[g])));
    end

    evlog_rr_arb #(.N(N_SRC)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (hold_v),
        .grant     (grant),
        .grant_idx (grant_idx),
        .grant_any (grant_any)
    );

    assign fifo_push = grant_any && !fifo_full;

    evlog_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (hold_d[grant_idx]),
        .pop   (fifo_pop),
        .head  (fifo_head),
        .count (fifo_count),
        .full  (fifo_full)
    );

    // Count discarded records, saturating at the maximum.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovf_q <= '0;
        else if (grant_any && fifo_full && ovf_q != OVF_MAX)
            ovf_q <= ovf_q + 1'b1;
    end

    evlog_framer #(.RECS(RECS_PER_FRAME), .CNT_W(CNT_W), .HDR_WORD(HDR_WORD)) u_frm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_count (fifo_count),
        .fifo_head  (fifo_head),
        .pop        (fifo_pop),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_last   (out_last),
        .out_ready  (out_ready)
    );

    a_r7_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_any && fifo_full && ovf_q != OVF_MAX) |=> (ovf_q == $past(ovf_q) + 1'b1));
    a_r8_ovf_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q == OVF_MAX) |=> (ovf_q == OVF_MAX));
    a_r7_ovf_only_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_any && fifo_full) |=> $stable(ovf_q));
endmodule

// File: tb/sim_evlog_packer.sv
`timescale 1ns/1ps
// Bench for evlog_packer: a behavioural reference model (queues and
// integers), compared with the outputs on every falling clock edge.
module sim_evlog_packer;
    localparam int          N     = 4;
    localparam int          DEPTH = 16;
    localparam int          RECS  = 10;
    localparam int          OW    = 4;
    localparam int          RW    = 61;
    localparam logic [63:0] HDR   = 64'hA5C3_0F1E_2D3C_4B5A;
    localparam int          OMAX  = (1 << OW) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N-1:0]      src_valid = '0;
    logic [N*RW-1:0]   src_rec;
    logic [N-1:0]      src_ready;
    logic              out_valid, out_last;
    logic              out_ready = 1'b0;
    logic [63:0]       out_data;
    logic [OW-1:0]     ovf_count;

    logic [RW-1:0]     srec [N];
    int                checks = 0, errors = 0, seq = 1;
    bit                done = 1'b0;
    logic [N-1:0]      gen_en = '0;
    int                rdy_mode = 0;

    // Model state.
    bit                m_hv [N];
    logic [RW-1:0]     m_hd [N];
    bit                m_acc [N];
    int                m_ptr = 0, m_st = 0, m_idx = 0, m_ovf = 0;
    logic [RW-1:0]     m_q [$];
    bit                m_stall = 1'b0;
    logic [63:0]       prev_data;

    always #2 clk = ~clk;

    always_comb
        for (int i = 0; i < N; i++) src_rec[i*RW +: RW] = srec[i];

    evlog_packer #(.N_SRC(N), .FIFO_DEPTH(DEPTH), .RECS_PER_FRAME(RECS),
                   .OVF_W(OW), .HDR_WORD(HDR)) u0 (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_rec(src_rec),
        .src_ready(src_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last), .out_ready(out_ready), .ovf_count(ovf_count));

    // Builds a unique record: id, time, pointer, hops, lag, port (R1 layout).
    function automatic logic [RW-1:0] mk(int src, int s);
        logic [11:0] id  = 12'(s);
        logic [18:0] tm  = 19'(s * 7 + src);
        logic [18:0] pt  = 19'(s * 189 + 1);
        logic [3:0]  hp  = 4'(s);
        logic [4:0]  lg  = 5'(s ^ src);
        logic [1:0]  pn  = 2'(src);
        return {id, tm, pt, hp, lg, pn};
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model step at each rising edge, using pre-edge values.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin m_hv[i] = 0; m_acc[i] = 0; end
            m_ptr = 0; m_st = 0; m_idx = 0; m_ovf = 0; m_q.delete(); m_stall = 0;
        end else begin
            int g, cnt0;
            g = -1;
            for (int k = 0; k < N; k++)
                if (g < 0 && m_hv[(m_ptr + k) % N]) g = (m_ptr + k) % N;
            cnt0 = m_q.size();
            m_stall = (m_st != 0) && !out_ready;
            if (m_st == 2 && out_ready) void'(m_q.pop_front());
            if (g >= 0) begin
                if (cnt0 < DEPTH) m_q.push_back(m_hd[g]);
                else if (m_ovf < OMAX) m_ovf++;
            end
            case (m_st)
                0: if (cnt0 >= RECS) m_st = 1;
                1: if (out_ready) begin m_st = 2; m_idx = 0; end
                default: if (out_ready) begin
                    if (m_idx == RECS - 1) m_st = 0; else m_idx++;
                end
            endcase
            for (int i = 0; i < N; i++) begin
                m_acc[i] = src_valid[i] && !m_hv[i];
                if (m_acc[i]) begin m_hv[i] = 1; m_hd[i] = srec[i]; end
                else if (i == g) m_hv[i] = 0;
            end
            if (g >= 0) m_ptr = (g + 1) % N;
        end
    end

    // Compare outputs with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [63:0] ed;
            ed = (m_st == 1) ? HDR : {3'b000, (m_q.size() > 0 ? m_q[0] : '0)};
            for (int i = 0; i < N; i++)
                chk(src_ready[i] == !m_hv[i], "R6 ready", 64'(src_ready[i]), 64'(!m_hv[i]));
            chk(out_valid == (m_st != 0), "R3 out_valid", 64'(out_valid), 64'(m_st != 0));
            if (m_st != 0) begin
                chk(out_data == ed, "R1 R2 R4 R5 out_data", out_data, ed);
                if (m_st == 2)
                    chk(out_data[63:61] == 3'b000, "R1 padding", 64'(out_data[63:61]), 64'd0);
            end
            chk(out_last == (m_st == 2 && m_idx == RECS - 1), "R2 out_last",
                64'(out_last), 64'(m_st == 2 && m_idx == RECS - 1));
            chk(int'(ovf_count) == m_ovf, "R7 R8 ovf_count", 64'(ovf_count), 64'(m_ovf));
            if (m_stall)
                chk(out_valid && out_data == prev_data, "R9 stall hold", out_data, prev_data);
            prev_data = out_data;
        end
    end

    // Producer and host-side drivers on falling edges.
    always @(negedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (gen_en[i] && rst_n) begin
                if (!src_valid[i] || m_acc[i]) begin
                    srec[i] = mk(i, seq);
                    seq++;
                    src_valid[i] = 1'b1;
                end
            end else begin
                src_valid[i] = 1'b0;
            end
        end
        case (rdy_mode)
            0: out_ready = 1'b1;
            1: out_ready = 1'($urandom_range(0, 1));
            default: out_ready = 1'b0;
        endcase
    end

    initial begin
        for (int i = 0; i < N; i++) srec[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R10: reset state.
        chk(src_ready == '1, "R10 src_ready", 64'(src_ready), 64'hF);
        chk(!out_valid, "R10 out_valid", 64'(out_valid), 64'd0);
        chk(ovf_count == '0, "R10 ovf_count", 64'(ovf_count), 64'd0);
        // Single producer, host always ready.
        gen_en = 4'b0001; rdy_mode = 0;
        repeat (60) @(negedge clk);
        // All producers contending (R5 ordering).
        gen_en = 4'b1111;
        repeat (120) @(negedge clk);
        // Random subsets with a random ready line (R9).
        rdy_mode = 1;
        for (int r = 0; r < 30; r++) begin
            gen_en = 4'($urandom);
            repeat (20) @(negedge clk);
        end
        // Full stall: FIFO fills, records drop, counter saturates (R7, R8).
        rdy_mode = 2; gen_en = 4'b1111;
        repeat (100) @(negedge clk);
        #1;
        chk(int'(ovf_count) == OMAX, "R8 saturated", 64'(ovf_count), 64'(OMAX));
        chk(out_valid, "R9 stalled valid", 64'(out_valid), 64'd1);
        // Drain.
        gen_en = '0; rdy_mode = 0;
        repeat (200) @(negedge clk);
        #1;
        chk(!out_valid, "R3 idle below batch", 64'(out_valid), 64'd0);
        chk(int'(ovf_count) == OMAX, "R8 held", 64'(ovf_count), 64'(OMAX));
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule